// File: doc/BRIEF.md
# Fractional Microsecond Timebase

This block turns a reference clock, which can run at any of several common crystal rates, into a steady one-microsecond timebase. A fractional divider adds a programmable step to an accumulator on every reference cycle. Whenever the accumulated value reaches a programmable modulus, the divider emits a one-cycle tick and takes the modulus back out of the accumulator. This gives an exact long-run 1 MHz rate even from references such as 19.2 MHz or 38.4 MHz, which are not whole multiples of 1 MHz.

Each tick advances a free-running microsecond counter. Software reads the counter over a small register bus, and it sets the ratio through a 16-bit setting register on the same bus. The tick pulse is also brought out as a port, so that neighbouring timers can count microseconds without dividers of their own.

Top module: `usec_timebase`

## Requirements
- R1: While `rst_n` is low, at the next clock edge the counter clears, the accumulator clears, `usec_tick` goes low and the setting register loads 0x000B (12 MHz reference).
- R2: Reads are combinational. Offset 0x10 returns the counter. Offset 0x14 returns the setting register zero-extended. Any other offset returns 0.
- R3: A write to offset 0x14 stores `bus_wdata[15:0]`. Bits [15:8] hold the step minus one and bits [7:0] hold the modulus minus one. Upper data bits are dropped and read back as 0.
- R4: On each clock edge without a setting write, the step is added to the accumulator. If the sum is at least the modulus, a tick is issued and the modulus is subtracted. From a restart with setting 0x000B, the first tick appears after the 12th edge.
- R5: `usec_tick` is high for exactly the cycles in which the counter has just advanced by one. The counter never changes in any other cycle.
- R6: The counter counts up by one per tick and wraps to 0 after its all-ones value.
- R7: A setting write restarts the accumulator from 0. In the following cycle there is no tick and the counter holds its value, even if a tick would otherwise have fallen on that edge.
- R8: Writes to offset 0x10, or to any offset other than 0x14, change neither the counter nor the setting register.
- R9: If the step exceeds the modulus, a tick is issued on every edge and the accumulator stays at 0.
- R10: Over a number of cycles equal to the modulus after a restart, exactly "step" ticks occur. For example: 0x000B gives 1 tick in 12 cycles, 0x045F gives 5 in 96, 0x0453 gives 5 in 84, and 0x04BF gives 5 in 192.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data |
| usec_tick | output | 1 | One-cycle microsecond tick |

## Verification
A setting write and a divider tick can fall on the same clock edge, and the restart must win: no tick and no counter advance. The bench provokes this directly by timing a rewrite of 0x000B to land on the 12th edge after a restart. Random traffic also sprays setting writes at arbitrary phases of the accumulator. A cycle-accurate model in the bench judges each of these cases by comparing the tick and the read data on every cycle.

// File: rtl/usec_timebase.sv
module usec_timebase #(
  parameter int CNT_W   = 32,
  parameter int FIELD_W = 8,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CNT_OFS = 'h10,
  parameter int CFG_OFS = 'h14,
  parameter int CFG_RST = 'h000B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              usec_tick
);
  localparam int CFG_W = 2 * FIELD_W;
  localparam int ACC_W = FIELD_W + 2;

  logic [CFG_W-1:0] cfg_q;
  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;

  logic [ACC_W-1:0] step, modulus, sum, acc_nxt;
  logic [CNT_W-1:0] cnt_inc;
  logic             fire, cfg_wr;

  assign cfg_wr  = bus_wr && (bus_addr == ADDR_W'(CFG_OFS));
  assign step    = {2'b00, cfg_q[CFG_W-1:FIELD_W]} + ACC_W'(1);
  assign modulus = {2'b00, cfg_q[FIELD_W-1:0]} + ACC_W'(1);
  assign sum     = acc_q + step;
  assign fire    = sum >= modulus;
  assign acc_nxt = !fire ? sum : (step > modulus) ? '0 : sum - modulus;
  assign cnt_inc = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= CFG_W'(CFG_RST);
      acc_q  <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cfg_wr) begin
      cfg_q  <= bus_wdata[CFG_W-1:0];
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_nxt;
      tick_q <= fire;
      if (fire) cnt_q <= cnt_inc;
    end
  end

  assign usec_tick = tick_q;

  always_comb begin
    if (bus_addr == ADDR_W'(CNT_OFS))      bus_rdata = DATA_W'(cnt_q);
    else if (bus_addr == ADDR_W'(CFG_OFS)) bus_rdata = DATA_W'(cfg_q);
    else                                   bus_rdata = '0;
  end

  // R5
  cnt_moves_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> usec_tick);

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usec_tick |-> cnt_q == $past(cnt_inc));

  // R7
  cfg_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (!usec_tick && $stable(cnt_q)));

  // R4
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < modulus);

  // R9
  fast_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step > modulus && !cfg_wr) |=> usec_tick);
endmodule

// File: tb/usec_timebase_tb_top.sv
module usec_timebase_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h10;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, w_rdata;
  logic usec_tick, w_tick;

  int checks = 0;
  int failures = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  usec_timebase dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .usec_tick(usec_tick));

  usec_timebase #(.CNT_W(4)) dut_w (
    .clk(clk), .rst_n(rst_n), .bus_wr(1'b0), .bus_addr(8'h10),
    .bus_wdata(32'h0), .bus_rdata(w_rdata), .usec_tick(w_tick));

  // reference model built from the requirements
  logic [15:0] m_cfg;
  int unsigned m_acc;
  logic [31:0] m_cnt;
  logic m_tick;

  always @(posedge clk) begin
    int unsigned st, md, sm;
    if (!rst_n) begin
      m_cfg <= 16'h000B; m_acc <= 0; m_cnt <= 0; m_tick <= 1'b0;
    end else if (bus_wr && bus_addr == 8'h14) begin
      m_cfg <= bus_wdata[15:0]; m_acc <= 0; m_tick <= 1'b0;
    end else begin
      st = m_cfg[15:8] + 1;
      md = m_cfg[7:0] + 1;
      sm = m_acc + st;
      if (sm >= md) begin
        m_tick <= 1'b1;
        m_cnt  <= m_cnt + 1;
        m_acc  <= (st > md) ? 0 : sm - md;
      end else begin
        m_tick <= 1'b0;
        m_acc  <= sm;
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    if (a == 8'h10) return m_cnt;
    if (a == 8'h14) return {16'h0, m_cfg};
    return 32'h0;
  endfunction

  function automatic int exp_ticks(input logic [15:0] c, input int cycles);
    return cycles * (c[15:8] + 1) / (c[7:0] + 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_en) begin
      check("R5 tick", {31'b0, usec_tick}, {31'b0, m_tick});
      check("R2 rdata", bus_rdata, exp_rd(bus_addr));
    end
  end

  // narrow-counter instance: wrap
  int w_ticks = 0;
  always @(negedge clk) begin
    if (chk_en && w_tick) begin
      w_ticks++;
      check("R6 wrap count", w_rdata, 32'(w_ticks % 16));
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic window(input logic [15:0] c, input int cycles, input string req);
    int n = 0;
    wr_reg(8'h14, {16'h0, c});
    bus_addr = 8'h10;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); @(negedge clk);
      if (usec_tick) n++;
    end
    check(req, 32'(n), 32'(exp_ticks(c, cycles)));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] saved;
    void'($urandom(32'd4242));
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 counter", bus_rdata, 32'h0);
    check("R1 tick", {31'b0, usec_tick}, 32'h0);
    bus_addr = 8'h14; #1;
    check("R1 setting", bus_rdata, 32'h0000_000B);
    bus_addr = 8'h20; #1;
    check("R2 unmapped", bus_rdata, 32'h0);
    chk_en = 1'b1;

    // R3 upper bits dropped
    wr_reg(8'h14, 32'hFFFF_045F);
    bus_addr = 8'h14; @(negedge clk);
    check("R3 readback", bus_rdata, 32'h0000_045F);

    // R10 crystal presets
    window(16'h000B, 120, "R10 12MHz");
    window(16'h045F, 96, "R10 19.2MHz");
    window(16'h0453, 84, "R10 16.8MHz");
    window(16'h04BF, 192, "R10 38.4MHz");
    window(16'h002F, 480, "R10 48MHz");

    // R4 first tick after restart
    wr_reg(8'h14, 32'h000B);
    bus_addr = 8'h10;
    repeat (11) @(posedge clk);
    @(negedge clk);
    check("R4 no tick at edge 11", {31'b0, usec_tick}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R4 tick at edge 12", {31'b0, usec_tick}, 32'h1);
    @(posedge clk); @(negedge clk);
    check("R4 single pulse", {31'b0, usec_tick}, 32'h0);

    // R7 write collides with a due tick
    wr_reg(8'h14, 32'h000B);
    bus_addr = 8'h10;
    repeat (11) @(posedge clk);
    #1 saved = bus_rdata;
    bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h000B;
    @(posedge clk); #1 bus_wr = 1'b0; bus_addr = 8'h10;
    @(negedge clk);
    check("R7 tick suppressed", {31'b0, usec_tick}, 32'h0);
    check("R7 counter held", bus_rdata, saved);

    // R8 ignored writes
    @(negedge clk) saved = bus_rdata;
    wr_reg(8'h10, 32'hFFFF_FFFF);
    bus_addr = 8'h10; @(negedge clk);
    check("R8 counter write ignored", bus_rdata, saved + (usec_tick ? 32'd1 : 32'd0));
    wr_reg(8'h30, 32'h0000_0000);
    bus_addr = 8'h14; @(negedge clk);
    check("R8 setting untouched", bus_rdata, 32'h0000_000B);

    // R9 step above modulus
    wr_reg(8'h14, 32'h0300);
    bus_addr = 8'h10;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); @(negedge clk);
      check("R9 tick every cycle", {31'b0, usec_tick}, 32'h1);
    end

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      @(posedge clk); #1;
      r = $urandom % 100;
      bus_wr = 1'b0;
      if (r < 3) begin
        bus_wr = 1'b1; bus_addr = 8'h14;
        case ($urandom % 6)
          0: bus_wdata = 32'h000C;
          1: bus_wdata = 32'h0019;
          2: bus_wdata = 32'h045F;
          3: bus_wdata = 32'h04BF;
          4: bus_wdata = 32'h000B;
          default: bus_wdata = $urandom;
        endcase
      end else if (r < 6) begin
        bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = $urandom;
      end else begin
        case ($urandom % 3)
          0: bus_addr = 8'h10;
          1: bus_addr = 8'h14;
          default: bus_addr = 8'($urandom);
        endcase
      end
    end
    @(posedge clk); #1 bus_wr = 1'b0;
    @(negedge clk);
    check("R6 wrap observed", {31'b0, w_ticks >= 16}, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule